// File: doc/BRIEF.md
# Boot-Time Code Security Controller

The controller decides whether the debug port may reach program memory. After every chip reset it opens a preboot window that lasts a fixed number of processor cycles. While that window is open, a status output is high and the debug port is shut out completely. Boot code that runs inside the window may arm a security bit by writing a one to a dedicated register address. That bit can be set but can never be cleared by a write. Writes that arrive after the window has closed are ignored.

Once the window has closed, the controller has two outcomes. If security is clear, the debug port is enabled and every debug request is granted. If security is set, only a global flash erase is granted and every other request is denied. Each request is answered one cycle later by a single-cycle grant pulse or a single-cycle deny pulse. A granted erase does not clear the security bit. Only the chip reset that follows the erase returns the part to the unsecured state. The flash controller that carries out the erase lies outside this block.

The design has three state machines:
- **Window FSM:**
  - `W_PRE` (window open) moves to `W_OPEN` on the processor step that counts the last preboot cycle.
  - `W_OPEN` is held until reset.
- **Lock FSM:**
  - `L_CLEAR` moves to `L_SECURED` when a qualifying write arrives while the window is open.
  - `L_SECURED` is held until reset.
- **Debug arbiter FSM:**
  - `A_IDLE`, `A_GRANT` and `A_DENY` are the three states.
  - A request moves the arbiter to `A_GRANT` when it is allowed and to `A_DENY` otherwise.
  - A cycle with no request returns the arbiter to `A_IDLE`.

Top module: `bootsec_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `preboot_o`=1, `secure_o`=0, `dbg_enable_o`=0, `erase_ok_o`=0, and neither `dbg_grant_o` nor `dbg_deny_o` is high.
- R2: `preboot_o` falls on the clock edge that samples the PREBOOT_CYCLES-th (default 32) cycle with `cpu_step_i`=1, and not before. Cycles with `cpu_step_i`=0 are not counted.
- R3: Once `preboot_o` has fallen, it stays low whatever `cpu_step_i` does until the next reset. The cycle counter saturates.
- R4: A write (`reg_wr_i`=1) to address SEC_ADDR (default 4'h3) with data bit SEC_BIT (default bit 0) equal to 1, in a cycle where `preboot_o`=1, sets `secure_o` from the next cycle on. This includes the cycle of the last counted step.
- R5: A write with that bit 0, or a write to any other address, never changes `secure_o`. In particular, a set bit is never cleared by a write.
- R6: A write that would set security in a cycle where `preboot_o`=0 is ignored.
- R7: While `preboot_o`=1, every debug request is denied, and `dbg_enable_o`=0 and `erase_ok_o`=0.
- R8: After the window with `secure_o`=0, `dbg_enable_o`=1, `erase_ok_o`=1, and every request of any operation is granted.
- R9: With `secure_o`=1 after the window:
  - Only operation 2'b11 (global erase) is granted.
  - Operations 2'b00 (code read), 2'b01 (code write) and 2'b10 (processor control) are denied.
  - `dbg_enable_o`=0 and `erase_ok_o`=1.
- R10: A request (`dbg_req_i`=1 in a cycle) yields exactly one grant pulse or one deny pulse in the next cycle. Back-to-back requests are each answered, and no pulse appears without a request.
- R11: A granted erase leaves `secure_o` set. Only a chip reset clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Chip reset, active low, asynchronous assert |
| cpu_step_i | input | 1 | Processor cycle advance |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W (4) | Register write address |
| reg_data_i | input | DATA_W (8) | Register write data |
| dbg_req_i | input | 1 | Debug request valid |
| dbg_op_i | input | 2 | Debug operation: 00 read, 01 write, 10 control, 11 global erase |
| preboot_o | output | 1 | Preboot window status |
| secure_o | output | 1 | Security armed |
| dbg_enable_o | output | 1 | Debug port may take control of the processor |
| dbg_grant_o | output | 1 | One-cycle grant for the previous cycle's request |
| dbg_deny_o | output | 1 | One-cycle deny for the previous cycle's request |
| erase_ok_o | output | 1 | Global erase permitted |

## Verification
Each result has a fixed latency after its stimulus:
- **Preboot status:** the window status changes on the edge that samples the last counted step.
- **Security:** a security write shows on the output one edge after the write cycle.
- **Debug answer:** the grant or deny pulse is due exactly one edge after the request cycle.

The driver drives inputs on the falling edge. Each expected answer goes into a queue tagged with the cycle it is due. The monitor compares only on the falling edge of that due cycle, and in every other cycle it requires both answer pulses to be low.

// File: rtl/bootsec_pkg.sv
package bootsec_pkg;

    typedef enum logic [1:0] {
        DBG_READ  = 2'b00,
        DBG_WRITE = 2'b01,
        DBG_CTRL  = 2'b10,
        DBG_ERASE = 2'b11
    } dbg_op_e;

    typedef enum logic {
        W_PRE  = 1'b0,
        W_OPEN = 1'b1
    } win_state_e;

    typedef enum logic {
        L_CLEAR   = 1'b0,
        L_SECURED = 1'b1
    } lock_state_e;

    typedef enum logic [1:0] {
        A_IDLE  = 2'b00,
        A_GRANT = 2'b01,
        A_DENY  = 2'b10
    } arb_state_e;

endpackage

// File: rtl/bootsec_window.sv
module bootsec_window #(
    parameter int PREBOOT_CYCLES = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    output logic preboot_o
);
    import bootsec_pkg::*;

    localparam int CNT_W = $clog2(PREBOOT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(PREBOOT_CYCLES - 1);
    localparam logic [CNT_W-1:0] SAT  = CNT_W'(PREBOOT_CYCLES);

    win_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= W_PRE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            W_PRE: begin
                if (step_i) begin
                    if (cnt_q == LAST) begin
                        state_d = W_OPEN;
                        cnt_d   = SAT;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            W_OPEN: begin
                cnt_d = SAT;
            end
            default: begin
                state_d = W_PRE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        preboot_o = (state_q == W_PRE);
    end

    assert_exit_on_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(preboot_o) |-> $past(step_i));

    assert_window_stays_shut_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == W_OPEN) |=> (state_q == W_OPEN));

    assert_count_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= SAT);

endmodule

// File: rtl/bootsec_lock.sv
module bootsec_lock #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter int SEC_ADDR = 3,
    parameter int SEC_BIT  = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              preboot_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              secure_o
);
    import bootsec_pkg::*;

    localparam logic [ADDR_W-1:0] SEC_A = ADDR_W'(SEC_ADDR);

    lock_state_e state_q, state_d;
    logic        arm_req;
    logic        unused_data;

    assign unused_data = ^data_i;
    assign arm_req     = wr_i && (addr_i == SEC_A) && data_i[SEC_BIT];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= L_CLEAR;
        else        state_q <= state_d;
    end

    // next state: set-only, and only while the window is open
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            L_CLEAR:   if (arm_req && preboot_i) state_d = L_SECURED;
            L_SECURED: state_d = L_SECURED;
            default:   state_d = L_CLEAR;
        endcase
    end

    // outputs
    always_comb begin
        secure_o = (state_q == L_SECURED);
    end

    assert_secure_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        secure_o |=> secure_o);

    assert_arm_only_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(secure_o) |-> $past(preboot_i));

endmodule

// File: rtl/bootsec_arbiter.sv
module bootsec_arbiter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       preboot_i,
    input  logic       secure_i,
    input  logic       req_i,
    input  logic [1:0] op_i,
    output logic       grant_o,
    output logic       deny_o,
    output logic       enable_o,
    output logic       erase_ok_o
);
    import bootsec_pkg::*;

    arb_state_e state_q, state_d;
    logic       allow;

    assign allow = !preboot_i && (!secure_i || (op_i == DBG_ERASE));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= A_IDLE;
        else        state_q <= state_d;
    end

    // next state: every request is answered in the following cycle
    always_comb begin
        state_d = A_IDLE;
        unique case (state_q)
            A_IDLE, A_GRANT, A_DENY: begin
                if (req_i) state_d = allow ? A_GRANT : A_DENY;
            end
            default: state_d = A_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        grant_o    = (state_q == A_GRANT);
        deny_o     = (state_q == A_DENY);
        enable_o   = !preboot_i && !secure_i;
        erase_ok_o = !preboot_i;
    end

    assert_single_answer_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && deny_o));

    assert_answer_needs_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o || deny_o) |-> $past(req_i));

    assert_no_grant_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> !$past(preboot_i));

    assert_secured_erase_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> (!$past(secure_i) || ($past(op_i) == DBG_ERASE)));

endmodule

// File: rtl/bootsec_ctrl.sv
module bootsec_ctrl #(
    parameter int PREBOOT_CYCLES = 32,
    parameter int ADDR_W         = 4,
    parameter int DATA_W         = 8,
    parameter int SEC_ADDR       = 3,
    parameter int SEC_BIT        = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_step_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0] reg_data_i,
    input  logic              dbg_req_i,
    input  logic [1:0]        dbg_op_i,
    output logic              preboot_o,
    output logic              secure_o,
    output logic              dbg_enable_o,
    output logic              dbg_grant_o,
    output logic              dbg_deny_o,
    output logic              erase_ok_o
);

    logic preboot;
    logic secure;

    bootsec_window #(
        .PREBOOT_CYCLES(PREBOOT_CYCLES)
    ) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (cpu_step_i),
        .preboot_o(preboot)
    );

    bootsec_lock #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .SEC_ADDR(SEC_ADDR),
        .SEC_BIT (SEC_BIT)
    ) u_lock (
        .clk      (clk),
        .rst_n    (rst_n),
        .preboot_i(preboot),
        .wr_i     (reg_wr_i),
        .addr_i   (reg_addr_i),
        .data_i   (reg_data_i),
        .secure_o (secure)
    );

    bootsec_arbiter u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .preboot_i (preboot),
        .secure_i  (secure),
        .req_i     (dbg_req_i),
        .op_i      (dbg_op_i),
        .grant_o   (dbg_grant_o),
        .deny_o    (dbg_deny_o),
        .enable_o  (dbg_enable_o),
        .erase_ok_o(erase_ok_o)
    );

    assign preboot_o = preboot;
    assign secure_o  = secure;

    assert_clean_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (preboot_o && !secure_o));

    assert_secured_port_shut_R9: assert property (@(posedge clk) disable iff (!rst_n)
        secure_o |-> !dbg_enable_o);

endmodule

// File: tb/test_bootsec_ctrl.sv
module test_bootsec_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpu_step_i = 1'b0;
    logic       reg_wr_i = 1'b0;
    logic [3:0] reg_addr_i = '0;
    logic [7:0] reg_data_i = '0;
    logic       dbg_req_i = 1'b0;
    logic [1:0] dbg_op_i = '0;
    logic       preboot_o, secure_o, dbg_enable_o, dbg_grant_o, dbg_deny_o, erase_ok_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    typedef struct {
        int    due;
        bit    grant;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    bootsec_ctrl i_bootsec_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_step_i(cpu_step_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_data_i(reg_data_i),
        .dbg_req_i(dbg_req_i), .dbg_op_i(dbg_op_i),
        .preboot_o(preboot_o), .secure_o(secure_o), .dbg_enable_o(dbg_enable_o),
        .dbg_grant_o(dbg_grant_o), .dbg_deny_o(dbg_deny_o), .erase_ok_o(erase_ok_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // monitor: compares answers in the cycle they are due
    always @(negedge clk) begin
        if (rst_n) begin
            if (sb.size() > 0 && sb[0].due == cyc) begin
                exp_t it;
                it = sb.pop_front();
                check({it.tag, " grant"}, int'(dbg_grant_o), int'(it.grant));
                check({it.tag, " deny"},  int'(dbg_deny_o),  int'(!it.grant));
            end else if (dbg_grant_o || dbg_deny_o) begin
                check("R10 pulse without request", 1, 0);
            end
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; cpu_step_i = 0; reg_wr_i = 0; dbg_req_i = 0;
        repeat (3) @(negedge clk);
        check("R1 preboot in reset", int'(preboot_o), 1);
        check("R1 secure in reset", int'(secure_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 preboot after reset", int'(preboot_o), 1);
        check("R1 secure after reset", int'(secure_o), 0);
        check("R1 enable after reset", int'(dbg_enable_o), 0);
        check("R1 erase_ok after reset", int'(erase_ok_o), 0);
        check("R1 no answer after reset", int'(dbg_grant_o | dbg_deny_o), 0);
    endtask

    task automatic steps(input int n);
        for (int i = 0; i < n; i++) begin
            cpu_step_i = 1'b1;
            @(negedge clk);
            cpu_step_i = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic stp);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_data_i = d; cpu_step_i = stp;
        @(negedge clk);
        reg_wr_i = 1'b0; cpu_step_i = 1'b0;
        @(negedge clk);
    endtask

    task automatic dbg_issue(input logic [1:0] op, input bit g, input string tag);
        exp_t it;
        dbg_req_i = 1'b1; dbg_op_i = op;
        it.due = cyc + 1; it.grant = g; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
    endtask

    task automatic dbg_idle();
        dbg_req_i = 1'b0;
        @(negedge clk);
        @(negedge clk);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // ---- run 1: security never armed
        do_reset();
        dbg_issue(2'b00, 0, "R7 read in window");
        dbg_issue(2'b11, 0, "R7 erase in window");
        dbg_idle();
        check("R7 enable in window", int'(dbg_enable_o), 0);
        check("R7 erase_ok in window", int'(erase_ok_o), 0);
        wr(4'h5, 8'h01, 0);
        check("R5 other address", int'(secure_o), 0);
        wr(4'h3, 8'hFE, 0);
        check("R5 bit zero write", int'(secure_o), 0);
        steps(31);
        check("R2 still open after 31 steps", int'(preboot_o), 1);
        steps(1);
        check("R2 closed after 32 steps", int'(preboot_o), 0);
        steps(50);
        check("R3 stays closed", int'(preboot_o), 0);
        wr(4'h3, 8'h01, 0);
        check("R6 late write ignored", int'(secure_o), 0);
        check("R8 enable", int'(dbg_enable_o), 1);
        check("R8 erase_ok", int'(erase_ok_o), 1);
        dbg_issue(2'b00, 1, "R8 read");
        dbg_issue(2'b01, 1, "R8 R10 back-to-back write");
        dbg_issue(2'b10, 1, "R8 R10 back-to-back ctrl");
        dbg_idle();
        dbg_issue(2'b11, 1, "R8 erase");
        dbg_idle();

        // ---- run 2: armed early
        do_reset();
        wr(4'h3, 8'h01, 0);
        check("R4 armed in window", int'(secure_o), 1);
        wr(4'h3, 8'h00, 0);
        check("R5 zero write keeps set", int'(secure_o), 1);
        steps(32);
        check("R2 closed run 2", int'(preboot_o), 0);
        check("R9 enable off", int'(dbg_enable_o), 0);
        check("R9 erase_ok", int'(erase_ok_o), 1);
        dbg_issue(2'b00, 0, "R9 read denied");
        dbg_issue(2'b01, 0, "R9 write denied");
        dbg_issue(2'b10, 0, "R9 ctrl denied");
        dbg_issue(2'b11, 1, "R9 erase granted");
        dbg_idle();
        check("R11 erase keeps secure", int'(secure_o), 1);
        do_reset();
        check("R11 reset clears secure", int'(secure_o), 0);

        // ---- run 3: arm on the last counted step
        steps(31);
        wr(4'h3, 8'h01, 1);
        check("R4 arm on last step", int'(secure_o), 1);
        check("R2 closed run 3", int'(preboot_o), 0);
        dbg_issue(2'b00, 0, "R9 read denied run 3");
        dbg_idle();
        check("R10 queue drained", sb.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule